// File: doc/BRIEF.md
# Serial Display Command Decoder

This block sits between a host microcontroller and the memories and control registers of a dot-matrix character display. The host talks to it over a three-wire link made of an active-low select, a shift clock and a data line. The block samples the data line on each rising edge of the shift clock and collects eight bits into a byte, least significant bit first. Every byte is then decoded in the block's own system clock domain. The first complete byte of a transaction is the command. For the three memory commands that byte also carries the start address. Every later byte in the same transaction writes the next memory entry.

The block produces single-cycle write strobes, each with its address and data, for three memories:
- a 16-entry character-code memory, 8 bits wide;
- an 8-entry user-pattern memory, 35 bits wide, where each word is built from five column bytes;
- a 16-entry symbol memory, 2 bits wide.

It also holds the static outputs: the two general-purpose port bits, the brightness duty code, the digit-count code, the display-control bits and a test-mode flag. When the select line falls while the standby bit is set, the block wakes up and clears both the display-on bit and the standby bit.

Top module: `sdc_top`

## Requirements
- R1: While `cs_n_i` is low, the block takes one bit from `sdi_i` on each rising edge of `sck_i`. Eight bits form a byte, and the first bit received is bit 0.
- R2: Bits 7:5 of the first byte of a transaction give the opcode. The register opcodes are: 011 loads `port_o` from bits 1:0, 100 loads `duty_o` from bits 2:0, 101 loads `digits_o` from bits 2:0, and 110 loads `dctl_o` from bits 3:0. Any further bytes after a register opcode in the same transaction are ignored.
- R3: Opcode 000 starts a character-memory write at the address in bits 3:0. Each following byte produces one `chr_we_o` pulse carrying the current address and the byte. The address then steps by 1, and it goes from 15 back to 0.
- R4: Opcode 010 starts a symbol-memory write at the address in bits 3:0. Each following byte produces one `sym_we_o` pulse whose data is bits 1:0 of that byte. The address steps by 1 and goes from 15 back to 0.
- R5: Opcode 001 starts a pattern-memory write at the address in bits 2:0. Data bytes come in groups of five. In column byte k (k = 0 to 4), bit i (i = 0 to 6) becomes word bit 5*i+k, and bit 7 is ignored. After the fifth byte, one `pat_we_o` pulse writes the word. The address then steps by 1 and goes from 7 back to 0.
- R6: After reset, `port_o` is 11, `duty_o`, `digits_o` and `dctl_o` are all 0, `test_mode_o` is 0, no write strobe is active, and all three memory addresses are 0.
- R7: `test_mode_o` is set only by the command byte 0xE0, and only when `test_en_i` is high. Any other byte with opcode 111 changes nothing.
- R8: `dctl_o` is ordered {display-on, standby, all-on, all-off}. A falling edge on `cs_n_i` while the standby bit (bit 2) is 1 clears bits 3 and 2. The same edge with the standby bit at 0 changes nothing.
- R9: A rising edge on `cs_n_i` ends the transaction. Any partial byte and any unfinished five-byte pattern group are discarded, and the next byte is decoded as a command.
- R10: Each write strobe lasts exactly one system clock cycle, and no two write strobes are ever active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial shift clock |
| sdi_i | input | 1 | Serial data, least significant bit first |
| test_en_i | input | 1 | Allows the test command |
| chr_we_o | output | 1 | Character memory write strobe |
| chr_addr_o | output | 4 | Character memory write address |
| chr_data_o | output | 8 | Character memory write data |
| pat_we_o | output | 1 | Pattern memory write strobe |
| pat_addr_o | output | 3 | Pattern memory write address |
| pat_data_o | output | 35 | Assembled pattern word |
| sym_we_o | output | 1 | Symbol memory write strobe |
| sym_addr_o | output | 4 | Symbol memory write address |
| sym_data_o | output | 2 | Symbol memory write data |
| port_o | output | 2 | General port bits {P2,P1} |
| duty_o | output | 3 | Duty code |
| digits_o | output | 3 | Digit-count code |
| dctl_o | output | 4 | Display-control bits {display-on, standby, all-on, all-off} |
| test_mode_o | output | 1 | Test command accepted |

## Verification
Two events can fall in the same cycle. The first is a write to the top address of a memory, which in that same cycle steps the pointer back to zero. The bench provokes this by starting long streams close to the top address: a character stream starting at 14, a symbol stream starting at 3, and pattern groups starting at 6. It then judges the full logged sequence of write addresses and data against values it computes itself. The second case is a select rising edge that lands in the middle of a byte or a pattern group. The bench judges this by counting the strobes that follow and by checking that the next byte is decoded as a command.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int PAT_COLS = 5;
  localparam int PAT_ROWS = 7;
  localparam int PAT_W    = PAT_COLS * PAT_ROWS;
  localparam logic [7:0] TEST_CODE = 8'hE0;

  typedef enum logic [2:0] {
    OP_CHR  = 3'b000,
    OP_PAT  = 3'b001,
    OP_SYM  = 3'b010,
    OP_PORT = 3'b011,
    OP_DUTY = 3'b100,
    OP_DIGS = 3'b101,
    OP_DCTL = 3'b110,
    OP_TEST = 3'b111
  } op_t;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_CHR,
    TGT_PAT,
    TGT_SYM
  } tgt_t;

  localparam int DC_DISP = 3;
  localparam int DC_STBY = 2;

  // Place one column byte into a pattern word: row i of column k lands at bit PAT_COLS*i+k.
  function automatic logic [PAT_W-1:0] pat_merge(input logic [PAT_W-1:0] acc,
                                                 input logic [7:0] col_byte,
                                                 input int col);
    logic [PAT_W-1:0] r;
    r = acc;
    for (int i = 0; i < PAT_ROWS; i++) r[PAT_COLS*i + col] = col_byte[i];
    return r;
  endfunction
endpackage

// File: rtl/sdc_serial_rx.sv
module sdc_serial_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              cs_high_o,
  output logic              cs_fall_o,
  output logic              byte_stb_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [SYNC_STAGES-1:0] cs_s, sck_s, sdi_s;
  logic cs_d, sck_d;
  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;

  wire cs_q      = cs_s[SYNC_STAGES-1];
  wire sck_q     = sck_s[SYNC_STAGES-1];
  wire sdi_q     = sdi_s[SYNC_STAGES-1];
  wire sck_rise  = sck_q & ~sck_d;
  wire bit_take  = sck_rise & ~cs_q;
  wire last_bit  = (cnt_q == CNT_W'(BYTE_W-1));
  wire [BYTE_W-1:0] sh_next = {sdi_q, sh_q[BYTE_W-1:1]};

  assign cs_high_o = cs_q;
  assign cs_fall_o = ~cs_q & cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s <= '1; sck_s <= '1; sdi_s <= '0;
      cs_d <= 1'b1; sck_d <= 1'b1;
    end else begin
      cs_s  <= {cs_s[SYNC_STAGES-2:0], cs_n_i};
      sck_s <= {sck_s[SYNC_STAGES-2:0], sck_i};
      sdi_s <= {sdi_s[SYNC_STAGES-2:0], sdi_i};
      cs_d  <= cs_q;
      sck_d <= sck_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; cnt_q <= '0; byte_stb_o <= 1'b0; byte_o <= '0;
    end else begin
      byte_stb_o <= 1'b0;
      if (cs_q) begin
        cnt_q <= '0;
      end else if (bit_take) begin
        sh_q  <= sh_next;
        cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
        if (last_bit) begin
          byte_stb_o <= 1'b1;
          byte_o     <= sh_next;
        end
      end
    end
  end

  // R9
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> (cnt_q == '0));
  // R1
  byte_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb_o |-> !cs_d);
endmodule

// File: rtl/sdc_pat_asm.sv
module sdc_pat_asm import sdc_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             col_stb_i,
  input  logic [7:0]       col_byte_i,
  output logic             word_stb_o,
  output logic [PAT_W-1:0] word_o
);
  localparam int CW = $clog2(PAT_COLS);

  logic [CW-1:0] col_q;
  logic [PAT_W-1:0] acc_q;
  wire last_col = (col_q == CW'(PAT_COLS-1));
  wire [PAT_W-1:0] merged = pat_merge(acc_q, col_byte_i, int'(col_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0; acc_q <= '0; word_stb_o <= 1'b0; word_o <= '0;
    end else begin
      word_stb_o <= 1'b0;
      if (clr_i) begin
        col_q <= '0;
        acc_q <= '0;
      end else if (col_stb_i) begin
        if (last_col) begin
          word_stb_o <= 1'b1;
          word_o     <= merged;
          col_q      <= '0;
          acc_q      <= '0;
        end else begin
          acc_q <= merged;
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  // R5
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= CW'(PAT_COLS-1));
  // R9
  group_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (col_q == '0) && !word_stb_o);
endmodule

// File: rtl/sdc_cmd_dec.sv
module sdc_cmd_dec import sdc_pkg::*; #(
  parameter int CHR_AW = 4,
  parameter int PAT_AW = 3,
  parameter int SYM_AW = 4,
  parameter int SYM_DW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_high_i,
  input  logic              cs_fall_i,
  input  logic              byte_stb_i,
  input  logic [7:0]        byte_i,
  input  logic              test_en_i,
  input  logic              word_stb_i,
  input  logic [PAT_W-1:0]  word_i,
  output logic              col_stb_o,
  output logic              chr_we_o,
  output logic [CHR_AW-1:0] chr_addr_o,
  output logic [7:0]        chr_data_o,
  output logic              pat_we_o,
  output logic [PAT_AW-1:0] pat_addr_o,
  output logic [PAT_W-1:0]  pat_data_o,
  output logic              sym_we_o,
  output logic [SYM_AW-1:0] sym_addr_o,
  output logic [SYM_DW-1:0] sym_data_o,
  output logic [1:0]        port_o,
  output logic [2:0]        duty_o,
  output logic [2:0]        digits_o,
  output logic [3:0]        dctl_o,
  output logic              test_mode_o
);
  logic first_q;
  tgt_t tgt_q;
  logic [CHR_AW-1:0] chr_ptr;
  logic [PAT_AW-1:0] pat_ptr;
  logic [SYM_AW-1:0] sym_ptr;

  wire op_t op   = op_t'(byte_i[7:5]);
  wire cmd_stb   = byte_stb_i & first_q;
  wire data_stb  = byte_stb_i & ~first_q;
  wire wake_evt  = cs_fall_i & dctl_o[DC_STBY];
  wire test_hit  = cmd_stb && (op == OP_TEST) && (byte_i == TEST_CODE) && test_en_i;

  assign col_stb_o = data_stb && (tgt_q == TGT_PAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1; tgt_q <= TGT_NONE;
      chr_ptr <= '0; pat_ptr <= '0; sym_ptr <= '0;
      chr_we_o <= 1'b0; chr_addr_o <= '0; chr_data_o <= '0;
      pat_we_o <= 1'b0; pat_addr_o <= '0; pat_data_o <= '0;
      sym_we_o <= 1'b0; sym_addr_o <= '0; sym_data_o <= '0;
      port_o <= 2'b11; duty_o <= '0; digits_o <= '0; dctl_o <= '0;
      test_mode_o <= 1'b0;
    end else begin
      chr_we_o <= 1'b0;
      pat_we_o <= 1'b0;
      sym_we_o <= 1'b0;
      if (cs_high_i) begin
        first_q <= 1'b1;
        tgt_q   <= TGT_NONE;
      end
      if (wake_evt) begin
        dctl_o[DC_DISP] <= 1'b0;
        dctl_o[DC_STBY] <= 1'b0;
      end
      if (test_hit) test_mode_o <= 1'b1;
      if (cmd_stb) begin
        first_q <= 1'b0;
        tgt_q   <= TGT_NONE;
        case (op)
          OP_CHR:  begin tgt_q <= TGT_CHR; chr_ptr <= byte_i[CHR_AW-1:0]; end
          OP_PAT:  begin tgt_q <= TGT_PAT; pat_ptr <= byte_i[PAT_AW-1:0]; end
          OP_SYM:  begin tgt_q <= TGT_SYM; sym_ptr <= byte_i[SYM_AW-1:0]; end
          OP_PORT: port_o   <= byte_i[1:0];
          OP_DUTY: duty_o   <= byte_i[2:0];
          OP_DIGS: digits_o <= byte_i[2:0];
          OP_DCTL: dctl_o   <= byte_i[3:0];
          default: ;
        endcase
      end
      if (data_stb) begin
        case (tgt_q)
          TGT_CHR: begin
            chr_we_o <= 1'b1; chr_addr_o <= chr_ptr; chr_data_o <= byte_i;
            chr_ptr  <= chr_ptr + 1'b1;
          end
          TGT_SYM: begin
            sym_we_o <= 1'b1; sym_addr_o <= sym_ptr; sym_data_o <= byte_i[SYM_DW-1:0];
            sym_ptr  <= sym_ptr + 1'b1;
          end
          default: ;
        endcase
      end
      if (word_stb_i) begin
        pat_we_o <= 1'b1; pat_addr_o <= pat_ptr; pat_data_o <= word_i;
        pat_ptr  <= pat_ptr + 1'b1;
      end
    end
  end

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chr_we_o, pat_we_o, sym_we_o}));
  // R10
  chr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chr_we_o |=> !chr_we_o);
  // R8
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> !dctl_o[DC_DISP] && !dctl_o[DC_STBY]);
  // R7
  test_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_mode_o) |-> $past(test_en_i));
  // R9
  no_write_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_we_o || sym_we_o) |-> !$past(cs_high_i));
endmodule

// File: rtl/sdc_top.sv
module sdc_top import sdc_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int CHR_AW = 4,
  parameter int PAT_AW = 3,
  parameter int SYM_AW = 4,
  parameter int SYM_DW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              test_en_i,
  output logic              chr_we_o,
  output logic [CHR_AW-1:0] chr_addr_o,
  output logic [7:0]        chr_data_o,
  output logic              pat_we_o,
  output logic [PAT_AW-1:0] pat_addr_o,
  output logic [PAT_W-1:0]  pat_data_o,
  output logic              sym_we_o,
  output logic [SYM_AW-1:0] sym_addr_o,
  output logic [SYM_DW-1:0] sym_data_o,
  output logic [1:0]        port_o,
  output logic [2:0]        duty_o,
  output logic [2:0]        digits_o,
  output logic [3:0]        dctl_o,
  output logic              test_mode_o
);
  logic cs_high, cs_fall, byte_stb, col_stb, word_stb;
  logic [7:0] byte_val;
  logic [PAT_W-1:0] word;

  sdc_serial_rx #(.SYNC_STAGES(SYNC_STAGES), .BYTE_W(8)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sck_i(sck_i), .sdi_i(sdi_i),
    .cs_high_o(cs_high), .cs_fall_o(cs_fall), .byte_stb_o(byte_stb), .byte_o(byte_val)
  );

  sdc_pat_asm u_asm (
    .clk(clk), .rst_n(rst_n), .clr_i(cs_high), .col_stb_i(col_stb),
    .col_byte_i(byte_val), .word_stb_o(word_stb), .word_o(word)
  );

  sdc_cmd_dec #(.CHR_AW(CHR_AW), .PAT_AW(PAT_AW), .SYM_AW(SYM_AW), .SYM_DW(SYM_DW)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_high_i(cs_high), .cs_fall_i(cs_fall),
    .byte_stb_i(byte_stb), .byte_i(byte_val), .test_en_i(test_en_i),
    .word_stb_i(word_stb), .word_i(word), .col_stb_o(col_stb),
    .chr_we_o(chr_we_o), .chr_addr_o(chr_addr_o), .chr_data_o(chr_data_o),
    .pat_we_o(pat_we_o), .pat_addr_o(pat_addr_o), .pat_data_o(pat_data_o),
    .sym_we_o(sym_we_o), .sym_addr_o(sym_addr_o), .sym_data_o(sym_data_o),
    .port_o(port_o), .duty_o(duty_o), .digits_o(digits_o), .dctl_o(dctl_o),
    .test_mode_o(test_mode_o)
  );
endmodule

// File: tb/sdc_top_test.sv
module sdc_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b1, sdi = 1'b0, test_en = 1'b0;
  logic chr_we, pat_we, sym_we, test_mode;
  logic [3:0] chr_addr, sym_addr, dctl;
  logic [7:0] chr_data;
  logic [2:0] pat_addr, duty, digits;
  logic [34:0] pat_data;
  logic [1:0] sym_data, port;

  always #2.5 clk = ~clk;

  sdc_top uut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi), .test_en_i(test_en),
    .chr_we_o(chr_we), .chr_addr_o(chr_addr), .chr_data_o(chr_data),
    .pat_we_o(pat_we), .pat_addr_o(pat_addr), .pat_data_o(pat_data),
    .sym_we_o(sym_we), .sym_addr_o(sym_addr), .sym_data_o(sym_data),
    .port_o(port), .duty_o(duty), .digits_o(digits), .dctl_o(dctl), .test_mode_o(test_mode)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // write logs filled by the monitor
  int n_chr = 0, n_sym = 0, n_pat = 0, viol = 0;
  logic [3:0]  chr_a [0:63];
  logic [7:0]  chr_d [0:63];
  logic [3:0]  sym_a [0:63];
  logic [1:0]  sym_d [0:63];
  logic [2:0]  pat_a [0:15];
  logic [34:0] pat_d [0:15];
  logic prev_c = 1'b0, prev_p = 1'b0, prev_s = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (int'(chr_we) + int'(pat_we) + int'(sym_we) > 1) viol++;
      if ((chr_we && prev_c) || (pat_we && prev_p) || (sym_we && prev_s)) viol++;
      if (chr_we && n_chr < 64) begin chr_a[n_chr] = chr_addr; chr_d[n_chr] = chr_data; n_chr++; end
      if (sym_we && n_sym < 64) begin sym_a[n_sym] = sym_addr; sym_d[n_sym] = sym_data; n_sym++; end
      if (pat_we && n_pat < 16) begin pat_a[n_pat] = pat_addr; pat_d[n_pat] = pat_data; n_pat++; end
    end
    prev_c = chr_we; prev_p = pat_we; prev_s = sym_we;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic txn_open();
    @(negedge clk); cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sdi = b[i]; sck = 1'b0;
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic txn_close();
    repeat (8) @(negedge clk); cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic one_cmd(input logic [7:0] b);
    txn_open(); send_byte(b); txn_close();
  endtask

  function automatic logic [34:0] build_word(input logic [7:0] c0, input logic [7:0] c1,
                                             input logic [7:0] c2, input logic [7:0] c3,
                                             input logic [7:0] c4);
    logic [7:0] cols [5];
    logic [34:0] w;
    cols[0] = c0; cols[1] = c1; cols[2] = c2; cols[3] = c3; cols[4] = c4;
    for (int b = 0; b < 35; b++) w[b] = cols[b % 5][b / 5];
    return w;
  endfunction

  initial begin
    #(5ns * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] pb [15];
    int base;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 reset state
    check(port == 2'b11, "R6 port", port, 2'b11);
    check(duty == 0 && digits == 0, "R6 duty/digits", {duty, digits}, 0);
    check(dctl == 0 && !test_mode, "R6 dctl/test", {dctl, test_mode}, 0);
    check(!chr_we && !pat_we && !sym_we, "R6 strobes", {chr_we, pat_we, sym_we}, 0);

    // R3 + R1: character stream from 14 across the wrap
    txn_open(); send_byte(8'h0E);
    for (int j = 0; j < 18; j++) send_byte(8'(8'h3C + j * 53));
    txn_close();
    check(n_chr == 18, "R3 count", n_chr, 18);
    for (int j = 0; j < 18; j++) begin
      check(chr_a[j] == 4'((14 + j) % 16), "R3 addr", chr_a[j], (14 + j) % 16);
      check(chr_d[j] == 8'(8'h3C + j * 53), "R1 data", chr_d[j], 8'(8'h3C + j * 53));
    end

    // R4 symbol stream from 3, wraps after 15
    txn_open(); send_byte(8'h53);
    for (int j = 0; j < 15; j++) send_byte(8'(j * 29 + 7));
    txn_close();
    check(n_sym == 15, "R4 count", n_sym, 15);
    for (int j = 0; j < 15; j++) begin
      check(sym_a[j] == 4'((3 + j) % 16), "R4 addr", sym_a[j], (3 + j) % 16);
      check(sym_d[j] == 2'((j * 29 + 7) % 4), "R4 data", sym_d[j], (j * 29 + 7) % 4);
    end

    // R5 pattern groups from 6 wrap to 0; bit 7 of each column set as junk
    for (int j = 0; j < 15; j++) pb[j] = 8'(8'h80 | ((j * 71 + 19) % 128));
    txn_open(); send_byte(8'h36);
    for (int j = 0; j < 15; j++) send_byte(pb[j]);
    txn_close();
    check(n_pat == 3, "R5 count", n_pat, 3);
    for (int g = 0; g < 3; g++) begin
      base = g * 5;
      check(pat_a[g] == 3'((6 + g) % 8), "R5 addr", pat_a[g], (6 + g) % 8);
      check(pat_d[g] == build_word(pb[base], pb[base+1], pb[base+2], pb[base+3], pb[base+4]),
            "R5 word", pat_d[g],
            build_word(pb[base], pb[base+1], pb[base+2], pb[base+3], pb[base+4]));
    end

    // R2 register sweeps with junk in unused bits
    for (int c = 0; c < 4; c++) begin
      one_cmd(8'(8'h7C | c));
      check(port == 2'(c), "R2 port", port, c);
    end
    for (int c = 0; c < 8; c++) begin
      one_cmd(8'(8'h98 | c));
      check(duty == 3'(c), "R2 duty", duty, c);
      one_cmd(8'(8'hB8 | c));
      check(digits == 3'(c), "R2 digits", digits, c);
    end
    for (int c = 0; c < 16; c++) begin
      one_cmd(8'(8'hD0 | c));
      check(dctl == 4'(c), "R2 dctl", dctl, c);
    end
    // R2 trailing bytes after a register command are ignored
    txn_open(); send_byte(8'h95); send_byte(8'h07); send_byte(8'h02); txn_close();
    check(duty == 3'd5, "R2 trailing ignored", duty, 5);
    check(n_chr == 18 && n_sym == 15 && n_pat == 3, "R2 no writes", n_chr, 18);

    // R8 wake from standby
    one_cmd(8'hCF);
    check(dctl == 4'hF, "R8 set standby", dctl, 4'hF);
    txn_open(); txn_close();
    check(dctl == 4'h3, "R8 wake", dctl, 4'h3);
    one_cmd(8'hCB);
    txn_open(); txn_close();
    check(dctl == 4'hB, "R8 no standby", dctl, 4'hB);

    // R7 test command gating
    test_en = 1'b0; one_cmd(8'hE0);
    check(!test_mode, "R7 disabled", test_mode, 0);
    test_en = 1'b1; one_cmd(8'hE1);
    check(!test_mode, "R7 wrong code", test_mode, 0);
    one_cmd(8'hE0);
    check(test_mode, "R7 accepted", test_mode, 1);
    test_en = 1'b0;

    // R9 partial byte discarded, next byte is a command
    txn_open(); send_byte(8'h05); send_byte(8'hA7); send_bits(8'hFF, 3); txn_close();
    check(n_chr == 19, "R9 one write", n_chr, 19);
    check(chr_a[18] == 4'h5 && chr_d[18] == 8'hA7, "R9 write", {chr_a[18], chr_d[18]}, 12'h5A7);
    one_cmd(8'h62);
    check(port == 2'b10 && n_chr == 19, "R9 command after cs", {port, 8'(n_chr)}, {2'b10, 8'd19});
    // R9 unfinished pattern group dropped
    txn_open(); send_byte(8'h20); send_byte(8'h7F); send_byte(8'h7F); send_byte(8'h7F); txn_close();
    check(n_pat == 3, "R9 group dropped", n_pat, 3);
    txn_open(); send_byte(8'h21);
    send_byte(8'h01); send_byte(8'h02); send_byte(8'h04); send_byte(8'h08); send_byte(8'h10);
    txn_close();
    check(n_pat == 4 && pat_a[3] == 3'd1, "R9 fresh group", pat_a[3], 1);
    check(pat_d[3] == build_word(8'h01, 8'h02, 8'h04, 8'h08, 8'h10), "R9 fresh word",
          pat_d[3], build_word(8'h01, 8'h02, 8'h04, 8'h08, 8'h10));

    // R10 strobe width and exclusivity across the whole run
    check(viol == 0, "R10 strobes", viol, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule